// File: doc/BRIEF.md
# Migratory Sharing Detection Directory

This block is the per-line directory controller of a home node. It accepts one coherence request per cycle: an ordinary read, a read-for-ownership, an upgrade of a shared copy, or a store notice from a processor that holds the line. Each request names the requesting processor and the line index. One cycle later the block answers with a grant state for the requester. It also reports the processor that must forward the data, and the set of other processors whose copies must be invalidated.

For every line the directory keeps a state, an owner pointer to the last exclusive holder, and a full sharer vector. It also keeps a short access history. A processor that reads a line and then asks to write it, while the owner is some other processor, completes one read-then-write handoff. When the handoff count reaches a threshold, the line is marked migratory. The next ordinary read to it is then answered with an exclusive grant in a separate migratory state, which saves the later upgrade. The migratory state becomes plain exclusive when the holder reports its first store. If another processor asks for the line before that store, the conversion is reverted. Once a line has been reverted a set number of times, conversion is switched off for that line for good.

Top module: `mig_dir_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` and `fwd_valid` are 0. `req_ready` is 1 whenever reset is low. All lines start uncached, with no owner, no sharers and zeroed history.
- R2: Every request accepted at a clock edge (`req_valid` and `req_ready` both high) produces exactly one response on the next edge. That response has `rsp_valid`=1 and echoes the request's `req_id` and `req_line`. A cycle with no accepted request gives `rsp_valid`=0 at the next edge.
- R3: Request kinds are encoded as read=0, read-for-ownership=1, upgrade=2, store notice=3. Grants are encoded as invalid=0, shared=1, exclusive=2, exclusive-migratory=3. A read to a line that is not marked migratory is granted shared (1) and adds the requester to the sharers. If another processor holds the line exclusively (grant 2 or 3), that holder is named in `fwd_id` with `fwd_valid`=1.
- R4: A read-for-ownership or upgrade is granted exclusive (2). `inval_mask` is the sharer set without the requester. The previous exclusive holder is forwarded to if it is another processor. Afterwards the requester is the sole sharer and the owner.
- R5: The handoff counter of a line advances when processor P asks for ownership and three conditions hold: the line's most recent access was an ordinary read by P, the owner pointer names a different processor, and the line is neither marked nor disabled. When the count reaches CONV_THRESH, the line is marked. Every ordinary read to a marked line is granted exclusive-migratory (3) with `rsp_converted`=1.
- R6: A store notice from the holder of an exclusive-migratory line turns it into plain exclusive and is answered with grant 2. The line stays marked, so a later read from another processor is converted again without a revert.
- R7: Any read, read-for-ownership or upgrade from a processor other than the holder of an exclusive-migratory line sets `rsp_revert`=1. It clears the mark and the handoff counter, and the request is serviced as if the line were unmarked. A read in that case gets grant 1 with `rsp_converted`=0.
- R8: On the REVERT_THRESH-th revert of a line, conversion is disabled for that line permanently. No later request to it is converted, whatever handoffs follow. A value of 0 never disables.
- R9: Counters, marks and disable state are per line. Activity on one line changes no grant or conversion decision on another.
- R10: `inval_mask` never includes the requester, and `fwd_id` never names the requester while `fwd_valid` is 1.
- R11: A store notice from a processor that is not the exclusive holder leaves the line unchanged and is answered with grant 0, without forwarding or invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_kind | input | 2 | Request kind (read, ownership, upgrade, store notice) |
| req_id | input | $clog2(NUM_PROCS) | Requesting processor |
| req_line | input | $clog2(NUM_LINES) | Line index |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(NUM_PROCS) | Requester of the answered request |
| rsp_line | output | $clog2(NUM_LINES) | Line of the answered request |
| rsp_grant | output | 2 | Granted state |
| rsp_converted | output | 1 | Read was turned into an exclusive-migratory grant |
| rsp_revert | output | 1 | Migratory break observed, conversion cleared |
| fwd_valid | output | 1 | Data must come from another holder |
| fwd_id | output | $clog2(NUM_PROCS) | Holder that forwards the data |
| inval_mask | output | NUM_PROCS | Processors to invalidate |

## Verification
The permanent switch-off is the hardest state to reach from the ports. A line has to be trained through CONV_THRESH read-then-upgrade handoffs between two processors, converted on a third processor's read, and broken by a fourth processor's request before any store notice. That full cycle has to repeat REVERT_THRESH times. Only then can the bench show that a further round of training no longer converts. The stimulus drives these rounds as directed sequences from a reusable training task. It mixes in random traffic that is biased toward processor pairs alternating reads and upgrades on a few lines, and compares every response against a bench model built from the requirements.

// File: rtl/mig_dir_pkg.sv
package mig_dir_pkg;

   typedef enum logic [1:0] {
      K_READ  = 2'd0,
      K_READX = 2'd1,
      K_UPGR  = 2'd2,
      K_STORE = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      G_INV = 2'd0,
      G_SHR = 2'd1,
      G_EXC = 2'd2,
      G_EXM = 2'd3
   } grant_e;

   // directory view of a line; values match grant encoding
   typedef enum logic [1:0] {
      L_NONE = 2'd0,
      L_SHR  = 2'd1,
      L_EXC  = 2'd2,
      L_EXM  = 2'd3
   } line_state_e;

   function automatic int cnt_width(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/mig_dir_table.sv
module mig_dir_table #(
   parameter int NUM_LINES = 8,
   parameter int ENTRY_W   = 16,
   localparam int LW       = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [LW-1:0]      rd_line,
   output logic [ENTRY_W-1:0] rd_entry,
   input  logic               wr_en,
   input  logic [LW-1:0]      wr_line,
   input  logic [ENTRY_W-1:0] wr_entry
);

   logic [ENTRY_W-1:0] store_q [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (rst) begin
            store_q[g] <= '0;
         end else if (wr_en && (wr_line == LW'(g))) begin
            store_q[g] <= wr_entry;
         end
      end
   end

   always_comb begin
      rd_entry = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (rd_line == LW'(i)) rd_entry = store_q[i];
      end
   end

endmodule

// File: rtl/mig_dir_policy.sv
module mig_dir_policy
   import mig_dir_pkg::*;
#(
   parameter int NUM_PROCS     = 4,
   parameter int CONV_THRESH   = 2,
   parameter int REVERT_THRESH = 3,
   parameter int ENTRY_W       = 16,
   localparam int IDW          = (NUM_PROCS < 2) ? 1 : $clog2(NUM_PROCS),
   localparam int CW           = cnt_width(CONV_THRESH),
   localparam int RW           = cnt_width(REVERT_THRESH)
) (
   input  req_kind_e            kind,
   input  logic [IDW-1:0]       id,
   input  logic [ENTRY_W-1:0]   cur_flat,
   output logic [ENTRY_W-1:0]   nxt_flat,
   output grant_e               grant,
   output logic                 converted,
   output logic                 brk,
   output logic                 fwd_v,
   output logic [IDW-1:0]       fwd_id,
   output logic [NUM_PROCS-1:0] inval
);

   typedef struct packed {
      line_state_e          lst;
      logic [IDW-1:0]       owner;
      logic                 owner_v;
      logic [NUM_PROCS-1:0] sh;
      logic [IDW-1:0]       last_rd;
      logic                 last_rd_v;
      logic [CW-1:0]        cnt;
      logic                 flag;
      logic [RW-1:0]        rev;
      logic                 dis;
   } entry_t;

   if ($bits(entry_t) != ENTRY_W) begin : g_bad_width
      $error("mig_dir_policy: ENTRY_W does not match entry layout");
   end

   // variant: a zero revert threshold never locks a line
   logic rev_lock_en;
   if (REVERT_THRESH == 0) begin : g_no_lock
      assign rev_lock_en = 1'b0;
   end else begin : g_lock
      assign rev_lock_en = 1'b1;
   end

   entry_t cur, e, n;
   logic [NUM_PROCS-1:0] self_bit;
   logic [NUM_PROCS-1:0] others;
   logic                 hold_other;
   logic                 handoff;

   assign cur      = entry_t'(cur_flat);
   assign nxt_flat = ENTRY_W'(n);
   assign self_bit = NUM_PROCS'(1) << id;
   assign others   = cur.sh & ~self_bit;
   assign fwd_id   = cur.owner;

   always_comb begin
      hold_other = ((cur.lst == L_EXC) || (cur.lst == L_EXM)) && cur.owner_v && (cur.owner != id);
      brk        = 1'b0;
      e          = cur;
      // break of an unwritten migratory grant by any other requester
      if ((kind != K_STORE) && (cur.lst == L_EXM) && (cur.owner != id)) begin
         brk    = 1'b1;
         e.flag = 1'b0;
         e.cnt  = '0;
         if (cur.rev != RW'(REVERT_THRESH)) e.rev = cur.rev + 1'b1;
         if (rev_lock_en && (({1'b0, cur.rev} + 1'b1) == (RW+1)'(REVERT_THRESH))) e.dis = 1'b1;
      end
   end

   always_comb begin
      n         = e;
      grant     = G_INV;
      converted = 1'b0;
      fwd_v     = 1'b0;
      inval     = '0;
      handoff   = 1'b0;
      unique case (kind)
         K_READ: begin
            fwd_v = hold_other;
            if (e.flag && !e.dis) begin
               grant       = G_EXM;
               converted   = 1'b1;
               inval       = others;
               n.lst       = L_EXM;
               n.owner     = id;
               n.owner_v   = 1'b1;
               n.sh        = self_bit;
               n.last_rd_v = 1'b0;
            end else begin
               grant       = G_SHR;
               n.lst       = L_SHR;
               n.sh        = e.sh | self_bit;
               n.last_rd   = id;
               n.last_rd_v = 1'b1;
            end
         end
         K_READX, K_UPGR: begin
            handoff = e.last_rd_v && (e.last_rd == id) && e.owner_v && (e.owner != id)
                      && !e.dis && !e.flag;
            if (handoff) begin
               if (e.cnt != CW'(CONV_THRESH)) n.cnt = e.cnt + 1'b1;
               if (({1'b0, e.cnt} + 1'b1) >= (CW+1)'(CONV_THRESH)) n.flag = 1'b1;
            end
            grant       = G_EXC;
            fwd_v       = hold_other;
            inval       = others;
            n.lst       = L_EXC;
            n.owner     = id;
            n.owner_v   = 1'b1;
            n.sh        = self_bit;
            n.last_rd_v = 1'b0;
         end
         default: begin
            if (cur.owner_v && (cur.owner == id) && ((cur.lst == L_EXC) || (cur.lst == L_EXM))) begin
               grant = G_EXC;
               n.lst = L_EXC;
            end
         end
      endcase
   end

endmodule

// File: rtl/mig_dir_rsp_reg.sv
module mig_dir_rsp_reg
   import mig_dir_pkg::*;
#(
   parameter int NUM_PROCS = 4,
   parameter int NUM_LINES = 8,
   localparam int IDW      = (NUM_PROCS < 2) ? 1 : $clog2(NUM_PROCS),
   localparam int LW       = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 acc,
   input  logic [IDW-1:0]       in_id,
   input  logic [LW-1:0]        in_line,
   input  grant_e               in_grant,
   input  logic                 in_conv,
   input  logic                 in_brk,
   input  logic                 in_fwd_v,
   input  logic [IDW-1:0]       in_fwd_id,
   input  logic [NUM_PROCS-1:0] in_inval,
   output logic                 rsp_valid,
   output logic [IDW-1:0]       rsp_id,
   output logic [LW-1:0]        rsp_line,
   output logic [1:0]           rsp_grant,
   output logic                 rsp_converted,
   output logic                 rsp_revert,
   output logic                 fwd_valid,
   output logic [IDW-1:0]       fwd_id,
   output logic [NUM_PROCS-1:0] inval_mask
);

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid     <= 1'b0;
         rsp_id        <= '0;
         rsp_line      <= '0;
         rsp_grant     <= 2'd0;
         rsp_converted <= 1'b0;
         rsp_revert    <= 1'b0;
         fwd_valid     <= 1'b0;
         fwd_id        <= '0;
         inval_mask    <= '0;
      end else begin
         rsp_valid     <= acc;
         rsp_id        <= in_id;
         rsp_line      <= in_line;
         rsp_grant     <= in_grant;
         rsp_converted <= acc && in_conv;
         rsp_revert    <= acc && in_brk;
         fwd_valid     <= acc && in_fwd_v;
         fwd_id        <= in_fwd_id;
         inval_mask    <= acc ? in_inval : '0;
      end
   end

endmodule

// File: rtl/mig_dir_ctrl.sv
module mig_dir_ctrl
   import mig_dir_pkg::*;
#(
   parameter int NUM_PROCS     = 4,
   parameter int NUM_LINES     = 8,
   parameter int CONV_THRESH   = 2,
   parameter int REVERT_THRESH = 3,
   localparam int IDW          = (NUM_PROCS < 2) ? 1 : $clog2(NUM_PROCS),
   localparam int LW           = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [1:0]           req_kind,
   input  logic [IDW-1:0]       req_id,
   input  logic [LW-1:0]        req_line,
   output logic                 rsp_valid,
   output logic [IDW-1:0]       rsp_id,
   output logic [LW-1:0]        rsp_line,
   output logic [1:0]           rsp_grant,
   output logic                 rsp_converted,
   output logic                 rsp_revert,
   output logic                 fwd_valid,
   output logic [IDW-1:0]       fwd_id,
   output logic [NUM_PROCS-1:0] inval_mask
);

   localparam int CW      = cnt_width(CONV_THRESH);
   localparam int RW      = cnt_width(REVERT_THRESH);
   localparam int ENTRY_W = 2 + IDW + 1 + NUM_PROCS + IDW + 1 + CW + 1 + RW + 1;

   if (NUM_PROCS < 2) begin : g_bad_procs
      $error("mig_dir_ctrl: NUM_PROCS must be at least 2");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("mig_dir_ctrl: NUM_LINES must be at least 1");
   end
   if (CONV_THRESH < 1) begin : g_bad_conv
      $error("mig_dir_ctrl: CONV_THRESH must be at least 1");
   end
   if (REVERT_THRESH < 0) begin : g_bad_rev
      $error("mig_dir_ctrl: REVERT_THRESH must not be negative");
   end

   logic                 acc;
   logic [ENTRY_W-1:0]   cur_entry;
   logic [ENTRY_W-1:0]   nxt_entry;
   grant_e               p_grant;
   logic                 p_conv;
   logic                 p_brk;
   logic                 p_fwd_v;
   logic [IDW-1:0]       p_fwd_id;
   logic [NUM_PROCS-1:0] p_inval;

   assign req_ready = !rst;
   assign acc       = req_valid && req_ready;

   mig_dir_table #(
      .NUM_LINES (NUM_LINES),
      .ENTRY_W   (ENTRY_W)
   ) u_table (
      .clk      (clk),
      .rst      (rst),
      .rd_line  (req_line),
      .rd_entry (cur_entry),
      .wr_en    (acc),
      .wr_line  (req_line),
      .wr_entry (nxt_entry)
   );

   mig_dir_policy #(
      .NUM_PROCS     (NUM_PROCS),
      .CONV_THRESH   (CONV_THRESH),
      .REVERT_THRESH (REVERT_THRESH),
      .ENTRY_W       (ENTRY_W)
   ) u_policy (
      .kind      (req_kind_e'(req_kind)),
      .id        (req_id),
      .cur_flat  (cur_entry),
      .nxt_flat  (nxt_entry),
      .grant     (p_grant),
      .converted (p_conv),
      .brk       (p_brk),
      .fwd_v     (p_fwd_v),
      .fwd_id    (p_fwd_id),
      .inval     (p_inval)
   );

   mig_dir_rsp_reg #(
      .NUM_PROCS (NUM_PROCS),
      .NUM_LINES (NUM_LINES)
   ) u_rsp (
      .clk           (clk),
      .rst           (rst),
      .acc           (acc),
      .in_id         (req_id),
      .in_line       (req_line),
      .in_grant      (p_grant),
      .in_conv       (p_conv),
      .in_brk        (p_brk),
      .in_fwd_v      (p_fwd_v),
      .in_fwd_id     (p_fwd_id),
      .in_inval      (p_inval),
      .rsp_valid     (rsp_valid),
      .rsp_id        (rsp_id),
      .rsp_line      (rsp_line),
      .rsp_grant     (rsp_grant),
      .rsp_converted (rsp_converted),
      .rsp_revert    (rsp_revert),
      .fwd_valid     (fwd_valid),
      .fwd_id        (fwd_id),
      .inval_mask    (inval_mask)
   );

endmodule

// File: rtl/mig_dir_checker.sv
module mig_dir_checker #(
   parameter int NUM_PROCS     = 4,
   parameter int NUM_LINES     = 8,
   parameter int CONV_THRESH   = 2,
   parameter int REVERT_THRESH = 3,
   localparam int IDW          = (NUM_PROCS < 2) ? 1 : $clog2(NUM_PROCS),
   localparam int LW           = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [1:0]           req_kind,
   input logic [IDW-1:0]       req_id,
   input logic [LW-1:0]        req_line,
   input logic                 rsp_valid,
   input logic [IDW-1:0]       rsp_id,
   input logic [LW-1:0]        rsp_line,
   input logic [1:0]           rsp_grant,
   input logic                 rsp_converted,
   input logic                 rsp_revert,
   input logic                 fwd_valid,
   input logic [IDW-1:0]       fwd_id,
   input logic [NUM_PROCS-1:0] inval_mask
);

   // reverts seen per line, counted from the response port
   logic [7:0] rev_seen [NUM_LINES];
   logic       lock_reached;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_rev
      always_ff @(posedge clk) begin
         if (rst) begin
            rev_seen[g] <= '0;
         end else if (rsp_valid && rsp_revert && (rsp_line == LW'(g)) && (rev_seen[g] != 8'hff)) begin
            rev_seen[g] <= rev_seen[g] + 8'd1;
         end
      end
   end

   always_comb begin
      lock_reached = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if ((rsp_line == LW'(i)) && (REVERT_THRESH > 0) && (32'(rev_seen[i]) >= REVERT_THRESH))
            lock_reached = 1'b1;
      end
   end

   a_r1_ready_out_of_reset: assert property (@(posedge clk) !rst |-> req_ready);

   a_r2_one_response: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> (rsp_valid && rsp_id == $past(req_id) && rsp_line == $past(req_line)));

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !(req_valid && req_ready) |=> !rsp_valid);

   a_r5_converted_grant: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_converted) |-> (rsp_grant == 2'd3));

   a_r5_migratory_only_when_converted: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_grant == 2'd3) |-> rsp_converted);

   a_r7_revert_not_converted: assert property (@(posedge clk) disable iff (rst)
      rsp_revert |-> (rsp_valid && !rsp_converted));

   a_r8_locked_line_never_converts: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && lock_reached) |-> !rsp_converted);

   a_r10_inval_excludes_requester: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> !inval_mask[rsp_id]);

   a_r10_fwd_not_requester: assert property (@(posedge clk) disable iff (rst)
      fwd_valid |-> (rsp_valid && fwd_id != rsp_id));

   a_r11_store_notice_quiet: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_kind == 2'd3) |=> (!fwd_valid && inval_mask == '0 && !rsp_revert));

endmodule

bind mig_dir_ctrl mig_dir_checker #(
   .NUM_PROCS     (NUM_PROCS),
   .NUM_LINES     (NUM_LINES),
   .CONV_THRESH   (CONV_THRESH),
   .REVERT_THRESH (REVERT_THRESH)
) u_chk (.*);

// File: tb/mig_dir_ctrl_test.sv
`timescale 1ns/1ps
module mig_dir_ctrl_test;

   localparam int P   = 4;
   localparam int L   = 8;
   localparam int CT  = 2;
   localparam int RT  = 3;
   localparam int IDW = 2;
   localparam int LW  = 3;

   logic           clk = 1'b0;
   logic           rst;
   logic           req_valid;
   logic           req_ready;
   logic [1:0]     req_kind;
   logic [IDW-1:0] req_id;
   logic [LW-1:0]  req_line;
   logic           rsp_valid;
   logic [IDW-1:0] rsp_id;
   logic [LW-1:0]  rsp_line;
   logic [1:0]     rsp_grant;
   logic           rsp_converted;
   logic           rsp_revert;
   logic           fwd_valid;
   logic [IDW-1:0] fwd_id;
   logic [P-1:0]   inval_mask;

   always #2 clk = ~clk;

   mig_dir_ctrl #(.NUM_PROCS(P), .NUM_LINES(L), .CONV_THRESH(CT), .REVERT_THRESH(RT)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_id(req_id), .req_line(req_line),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_line(rsp_line),
      .rsp_grant(rsp_grant), .rsp_converted(rsp_converted), .rsp_revert(rsp_revert),
      .fwd_valid(fwd_valid), .fwd_id(fwd_id), .inval_mask(inval_mask)
   );

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   // bench model of each line, built from the requirements
   int       m_st   [L];
   int       m_own  [L];
   bit       m_ov   [L];
   bit [P-1:0] m_sh [L];
   int       m_lr   [L];
   bit       m_lrv  [L];
   int       m_cnt  [L];
   bit       m_flag [L];
   int       m_rev  [L];
   bit       m_dis  [L];

   int       x_gr;
   bit       x_cv, x_rv, x_fv;
   int       x_fid;
   bit [P-1:0] x_inv;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < L; i++) begin
         m_st[i] = 0; m_own[i] = 0; m_ov[i] = 0; m_sh[i] = '0; m_lr[i] = 0;
         m_lrv[i] = 0; m_cnt[i] = 0; m_flag[i] = 0; m_rev[i] = 0; m_dis[i] = 0;
      end
   endfunction

   function automatic void model(int k, int id, int ln);
      bit         hold;
      bit         hand;
      bit [P-1:0] me;
      me    = P'(1) << id;
      hold  = (m_st[ln] >= 2) && m_ov[ln] && (m_own[ln] != id);
      x_gr  = 0; x_cv = 0; x_rv = 0; x_fv = 0; x_fid = m_own[ln]; x_inv = '0;
      if (k != 3 && m_st[ln] == 3 && m_own[ln] != id) begin
         x_rv = 1; m_flag[ln] = 0; m_cnt[ln] = 0;
         if (m_rev[ln] < RT) m_rev[ln]++;
         if (RT > 0 && m_rev[ln] >= RT) m_dis[ln] = 1;
      end
      if (k == 0) begin
         x_fv = hold;
         if (m_flag[ln] && !m_dis[ln]) begin
            x_gr = 3; x_cv = 1; x_inv = m_sh[ln] & ~me;
            m_st[ln] = 3; m_own[ln] = id; m_ov[ln] = 1; m_sh[ln] = me; m_lrv[ln] = 0;
         end else begin
            x_gr = 1; m_st[ln] = 1; m_sh[ln] = m_sh[ln] | me; m_lr[ln] = id; m_lrv[ln] = 1;
         end
      end else if (k == 1 || k == 2) begin
         hand = m_lrv[ln] && m_lr[ln] == id && m_ov[ln] && m_own[ln] != id && !m_dis[ln] && !m_flag[ln];
         if (hand) begin
            if (m_cnt[ln] < CT) m_cnt[ln]++;
            if (m_cnt[ln] >= CT) m_flag[ln] = 1;
         end
         x_gr = 2; x_fv = hold; x_inv = m_sh[ln] & ~me;
         m_st[ln] = 2; m_own[ln] = id; m_ov[ln] = 1; m_sh[ln] = me; m_lrv[ln] = 0;
      end else begin
         if (m_ov[ln] && m_own[ln] == id && m_st[ln] >= 2) begin
            x_gr = 2; m_st[ln] = 2;
         end
      end
   endfunction

   // called at a falling edge; leaves the bench at the next falling edge
   task automatic send(int k, int id, int ln);
      req_valid = 1'b1;
      req_kind  = 2'(k);
      req_id    = IDW'(id);
      req_line  = LW'(ln);
      model(k, id, ln);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 rsp_valid", 32'(rsp_valid), 1);
      chk("R2 rsp_id", 32'(rsp_id), 32'(id));
      chk("R2 rsp_line", 32'(rsp_line), 32'(ln));
      if (k == 0)      chk("R3 grant", 32'(rsp_grant), 32'(x_gr));
      else if (k == 3) chk("R11 grant", 32'(rsp_grant), 32'(x_gr));
      else             chk("R4 grant", 32'(rsp_grant), 32'(x_gr));
      chk("R5 converted", 32'(rsp_converted), 32'(x_cv));
      chk("R7 revert", 32'(rsp_revert), 32'(x_rv));
      chk("R10 fwd_valid", 32'(fwd_valid), 32'(x_fv));
      if (x_fv) chk("R10 fwd_id", 32'(fwd_id), 32'(x_fid));
      chk("R4 inval_mask", 32'(inval_mask), 32'(x_inv));
   endtask

   // two read-then-upgrade handoffs between a (current owner) and b
   task automatic train(int ln, int a, int b);
      send(0, b, ln);
      send(2, b, ln);
      send(0, a, ln);
      send(2, a, ln);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      req_valid = 1'b0; req_kind = 2'd0; req_id = '0; req_line = '0;
      rst = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
      chk("R1 fwd_valid in reset", 32'(fwd_valid), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready after reset", 32'(req_ready), 1);
      chk("R1 rsp_valid idle", 32'(rsp_valid), 0);

      // first migratory training on line 0
      send(1, 0, 0);
      chk("R4 first owner no fwd", 32'(fwd_valid), 0);
      train(0, 0, 1);
      send(0, 1, 0);
      chk("R5 read converted", 32'(rsp_converted), 1);
      chk("R5 grant migratory", 32'(rsp_grant), 3);
      send(3, 1, 0);
      chk("R6 store makes exclusive", 32'(rsp_grant), 2);
      send(0, 2, 0);
      chk("R6 converted again", 32'(rsp_converted), 1);
      chk("R6 no revert after store", 32'(rsp_revert), 0);
      send(0, 3, 0);
      chk("R7 break revert", 32'(rsp_revert), 1);
      chk("R7 break grant shared", 32'(rsp_grant), 1);
      send(0, 0, 0);
      chk("R7 mark cleared", 32'(rsp_converted), 0);
      @(negedge clk);
      chk("R2 idle no response", 32'(rsp_valid), 0);

      // two more break rounds reach the lock
      for (int r = 0; r < RT - 1; r++) begin
         send(1, 0, 0);
         train(0, 0, 1);
         send(0, 2, 0);
         chk("R5 retrained converts", 32'(rsp_converted), 1);
         send(0, 3, 0);
         chk("R7 repeated break", 32'(rsp_revert), 1);
      end
      send(1, 0, 0);
      train(0, 0, 1);
      send(0, 2, 0);
      chk("R8 locked line not converted", 32'(rsp_converted), 0);
      chk("R8 locked line shared grant", 32'(rsp_grant), 1);

      // other lines untouched
      send(0, 1, 1);
      chk("R9 other line plain read", 32'(rsp_grant), 1);
      chk("R9 other line not converted", 32'(rsp_converted), 0);
      send(3, 3, 1);
      chk("R11 store by non-owner", 32'(rsp_grant), 0);
      send(1, 2, 1);
      chk("R10 inval excludes requester", 32'(inval_mask[2]), 0);
      chk("R4 inval sharer", 32'(inval_mask), 32'b0010);

      // random traffic, biased toward migratory pairs
      for (int n = 0; n < 4000; n++) begin
         int ln, a, b, sel;
         sel = int'($urandom % 4);
         ln  = 1 + int'($urandom % 4);
         a   = int'($urandom % P);
         b   = (a + 1 + int'($urandom % (P - 1))) % P;
         if (sel == 0) begin
            send(int'($urandom % 4), a, int'($urandom % L));
         end else if (sel == 1) begin
            send(0, a, ln);
            send(2, a, ln);
         end else if (sel == 2) begin
            send(0, b, ln);
            if ($urandom % 2 == 0) send(3, b, ln);
         end else begin
            send(0, a, ln);
            if ($urandom % 3 == 0) begin
               @(negedge clk);
               chk("R2 gap no response", 32'(rsp_valid), 0);
            end
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule